// File: doc/BRIEF.md
# Conversion Clock Phase Adjuster

This block holds a signed phase correction written by a host and carries it out against a conversion-clock generator. The generator runs outside the block and divides the master clock. The correction is a sign bit and a magnitude. The magnitude counts master-clock cycles, and the sign chooses between pulling the conversion clock earlier (advance) and pushing it later (retard). The block applies the correction as one step request per master cycle. The generator answers each step request by removing one master cycle from the conversion period it is counting (advance) or adding one (retard). The held magnitude counts down with every step, so a read of the register shows how much of the shift is still pending.

Steps begin only at a conversion-period boundary, which the generator reports. Each period gives room for at most OSR-1 steps, where OSR is the number of master cycles in a nominal period. A magnitude below OSR therefore completes in the first period after the write. A larger magnitude is split: the first period takes OSR-1 steps and the next period takes the rest. A new value is accepted only once the previous correction has drained to zero. Transmit and receive each use their own instance.

Top module: `phase_adj`

## Requirements
- R1: The write value is MAG_W+1 bits wide. The top bit is the sign (0 = advance, 1 = retard) and the lower MAG_W bits are the magnitude. A write accepted while the remaining magnitude is zero appears on `remaining` in the next cycle. A value with magnitude zero, including a negative zero, reads back as all zeros.
- R2: Reset clears `remaining` to zero and deasserts `busy`, `step_adv` and `step_ret`.
- R3: The total number of step pulses equals the written magnitude. All of them appear on `step_adv` for sign 0 or all on `step_ret` for sign 1, and the two outputs are never high together.
- R4: Each step cycle lowers the remaining magnitude by exactly one. Once the shift is complete, `remaining` reads zero, `busy` is low and no further steps are issued.
- R5: A write arriving while the remaining magnitude is nonzero is ignored and leaves `remaining` unchanged.
- R6: After an accepted write, no step is issued until the cycle after the next `period_end` pulse. This holds even when the previous period had unused step room left over.
- R7: No more than OSR-1 steps are issued between two `period_end` pulses. A magnitude below OSR completes entirely in the first period after the write, provided the periods are at least OSR cycles long.
- R8: A magnitude of OSR or more issues OSR-1 steps in the first period and the remainder in the second, so it completes within two periods. No step falls in a third period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the phase value |
| wr_value | input | MAG_W+1 | Sign (top bit) and magnitude of the correction |
| period_end | input | 1 | One-cycle pulse from the generator at each conversion-period boundary |
| step_adv | output | 1 | Request to drop one master cycle from the current period |
| step_ret | output | 1 | Request to add one master cycle to the current period |
| remaining | output | MAG_W+1 | Read-back of the correction still pending (zero when done) |
| busy | output | 1 | High while a nonzero magnitude is pending |

## Verification
Several behaviours hold on every clock edge and are checked there: the two step outputs are exclusive and agree with the held sign, each step takes exactly one unit off the magnitude, an idle or locked-out register keeps its value, no step follows an accepted write directly, and the per-period step window never exceeds its room. The bench alone can show whole-shift outcomes. These are the exact total of steps for every magnitude and sign, how the steps split between the first and second periods around the OSR-1 limit, and the read-back of negative zero. It sweeps every value of a reduced configuration and computes each expected split arithmetically.

// File: rtl/phadj_pkg.sv
package phadj_pkg;

  typedef enum logic {
    PH_ADVANCE = 1'b0,
    PH_RETARD  = 1'b1
  } ph_dir_e;

  // room for steps inside one nominal conversion period
  function automatic int unsigned slack_cycles(int unsigned osr);
    return osr - 1;
  endfunction

endpackage

// File: rtl/phadj_value.sv
module phadj_value #(
  parameter int unsigned MAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  phadj_pkg::ph_dir_e     wr_dir,
  input  logic [MAG_W-1:0]       wr_mag,
  input  logic                   step_fire,
  output phadj_pkg::ph_dir_e     dir_q,
  output logic [MAG_W-1:0]       mag_q,
  output logic                   mag_nz,
  output logic                   wr_accept
);

  assign mag_nz    = |mag_q;
  // a new value is taken only once the previous shift has drained
  assign wr_accept = wr_en && !mag_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= phadj_pkg::PH_ADVANCE;
      mag_q <= '0;
    end else if (wr_accept) begin
      dir_q <= wr_dir;
      mag_q <= wr_mag;
    end else if (step_fire) begin
      mag_q <= mag_q - 1'b1;
    end
  end

endmodule

// File: rtl/phadj_budget.sv
module phadj_budget #(
  parameter int unsigned OSR = 144
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic period_end,
  input  logic step_fire,
  output logic budget_nz
);

  localparam int unsigned CW      = $clog2(OSR);
  localparam int unsigned SLACK_I = phadj_pkg::slack_cycles(OSR);
  localparam logic [CW-1:0] SLACK = CW'(SLACK_I);

  logic [CW-1:0] left_q;

  assign budget_nz = |left_q;

  // clear wins so a fresh value always waits for a real boundary;
  // leftover room is dropped at every boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (clear) begin
      left_q <= '0;
    end else if (period_end) begin
      left_q <= SLACK;
    end else if (step_fire) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/phase_adj.sv
module phase_adj #(
  parameter int unsigned MAG_W = 8,
  parameter int unsigned OSR   = 144
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MAG_W:0]   wr_value,
  input  logic             period_end,
  output logic             step_adv,
  output logic             step_ret,
  output logic [MAG_W:0]   remaining,
  output logic             busy
);

  import phadj_pkg::*;

  localparam int unsigned MAG_MAX = (1 << MAG_W) - 1;

  generate
    if (2 * slack_cycles(OSR) < MAG_MAX) begin : g_bad_cfg
      $error("phase_adj: two periods cannot absorb the largest magnitude");
    end
  endgenerate

  function automatic logic [MAG_W:0] readback(ph_dir_e d, logic [MAG_W-1:0] m);
    return (m == '0) ? '0 : {d == PH_RETARD, m};
  endfunction

  ph_dir_e           wr_dir;
  ph_dir_e           dir_q;
  logic [MAG_W-1:0]  mag_q;
  logic              mag_nz;
  logic              wr_accept;
  logic              budget_nz;
  logic              step_fire;

  assign wr_dir    = wr_value[MAG_W] ? PH_RETARD : PH_ADVANCE;
  assign step_fire = budget_nz && mag_nz;

  phadj_value #(.MAG_W(MAG_W)) u_value (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_dir    (wr_dir),
    .wr_mag    (wr_value[MAG_W-1:0]),
    .step_fire (step_fire),
    .dir_q     (dir_q),
    .mag_q     (mag_q),
    .mag_nz    (mag_nz),
    .wr_accept (wr_accept)
  );

  phadj_budget #(.OSR(OSR)) u_budget (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (wr_accept),
    .period_end (period_end),
    .step_fire  (step_fire),
    .budget_nz  (budget_nz)
  );

  assign step_adv  = step_fire && (dir_q == PH_ADVANCE);
  assign step_ret  = step_fire && (dir_q == PH_RETARD);
  assign remaining = readback(dir_q, mag_q);
  assign busy      = mag_nz;

endmodule

// File: rtl/phase_adj_chk.sv
module phase_adj_chk #(
  parameter int unsigned MAG_W = 8,
  parameter int unsigned OSR   = 144
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           period_end,
  input logic           step_adv,
  input logic           step_ret,
  input logic [MAG_W:0] remaining,
  input logic           busy,
  input logic           wr_accept
);

  localparam int unsigned CW = $clog2(OSR) + 1;
  localparam logic [CW-1:0] SLACK = CW'(OSR - 1);

  logic          any_step;
  logic [CW-1:0] win_cnt;

  assign any_step = step_adv || step_ret;

  always_ff @(posedge clk) begin
    if (!rst_n)          win_cnt <= '0;
    else if (period_end) win_cnt <= '0;
    else if (any_step)   win_cnt <= win_cnt + 1'b1;
  end

  // R3
  excl_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_adv && step_ret));

  // R3
  adv_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |-> !remaining[MAG_W]);

  // R3
  ret_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ret |-> remaining[MAG_W]);

  // R4
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_step |=> remaining[MAG_W-1:0] == $past(remaining[MAG_W-1:0]) - 1'b1);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining[MAG_W-1:0] == '0) |-> !any_step);

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !any_step) |=> $stable(remaining));

  // R6
  boundary_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !any_step);

  // R7
  window_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_step |-> win_cnt < SLACK);

endmodule

bind phase_adj phase_adj_chk #(.MAG_W(MAG_W), .OSR(OSR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .period_end (period_end),
  .step_adv   (step_adv),
  .step_ret   (step_ret),
  .remaining  (remaining),
  .busy       (busy),
  .wr_accept  (wr_accept)
);

// File: tb/phase_adj_tb.sv
module phase_adj_tb;

  localparam int MW    = 5;
  localparam int OSR   = 20;
  localparam int SLACK = OSR - 1;
  localparam int PER   = OSR;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          period_end = 1'b0;
  logic [MW:0]   wr_value = '0;
  logic          step_adv, step_ret, busy;
  logic [MW:0]   remaining;

  int n_chk = 0;
  int n_bad = 0;
  int seen;
  int per [3];
  bit done = 0;

  always #4 clk = ~clk;

  phase_adj #(.MAG_W(MW), .OSR(OSR)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_value   (wr_value),
    .period_end (period_end),
    .step_adv   (step_adv),
    .step_ret   (step_ret),
    .remaining  (remaining),
    .busy       (busy)
  );

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rb_exp(int d, int m);
    return (m == 0) ? 0 : (d << MW) | m;
  endfunction

  // sample at a falling edge; slot is the period a step belongs to
  task automatic observe(int d, int m, int slot, bit allow);
    int left;
    left = m - seen;
    chk("R4", int'(remaining), rb_exp(d, left), "remaining value");
    chk("R3", int'(step_adv && step_ret), 0, "both step lines high");
    if (step_adv || step_ret) begin
      if (!allow) chk("R6", 1, 0, "step before boundary");
      chk("R3", int'(step_ret), d, "step line vs sign");
      seen++;
      if (slot >= 0) per[slot]++;
    end
  endtask

  task automatic run_case(int d, int m);
    int first;
    @(negedge clk);
    chk("R4", int'(busy), 0, "idle before write");
    wr_en    = 1'b1;
    wr_value = {d[0], m[MW-1:0]};
    @(negedge clk);
    wr_en = 1'b0;
    seen  = 0;
    per   = '{0, 0, 0};
    chk("R1", int'(remaining), rb_exp(d, m), "read-back after write");
    chk("R4", int'(busy), int'(m != 0), "busy after write");
    for (int i = 0; i < 4; i++) begin
      observe(d, m, -1, 1'b0);
      if (i == 2 && m != 0) chk("R5", int'(remaining), rb_exp(d, m), "after locked write");
      wr_en = (i == 1 && m != 0);
      wr_value = {~d[0], ~m[MW-1:0]};
      @(negedge clk);
    end
    wr_en = 1'b0;
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < PER; c++) begin
        observe(d, m, (c == 0) ? p - 1 : p, !(p == 0 && c == 0));
        period_end = (c == 0);
        @(negedge clk);
      end
    end
    period_end = 1'b0;
    observe(d, m, 2, 1'b1);
    first = (m < SLACK) ? m : SLACK;
    chk("R4", int'(remaining), 0, "remaining at end");
    chk("R4", int'(busy), 0, "busy at end");
    chk("R3", seen, m, "total steps");
    chk("R7", per[0], first, "steps in first period");
    chk("R8", per[1], m - first, "steps in second period");
    chk("R8", per[2], 0, "steps in third period");
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", int'(remaining), 0, "remaining in reset");
    chk("R2", int'(busy), 0, "busy in reset");
    chk("R2", int'(step_adv || step_ret), 0, "steps in reset");
    rst_n = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < (1 << MW); m++)
        run_case(d, m);
    // reset in the middle of a shift
    @(negedge clk);
    wr_en = 1'b1;
    wr_value = {1'b1, 5'd25};
    @(negedge clk);
    wr_en = 1'b0;
    period_end = 1'b1;
    @(negedge clk);
    period_end = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", int'(step_ret), 1, "stepping before mid-run reset");
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2", int'(remaining), 0, "remaining after mid-run reset");
    chk("R2", int'(busy), 0, "busy after mid-run reset");
    chk("R2", int'(step_adv || step_ret), 0, "steps after mid-run reset");
    rst_n = 1'b1;
    @(negedge clk);
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

endmodule